// File: doc/BRIEF.md
# DisplayPort Link Rate and Ratio Selector

This block turns a requested pixel clock into a link setup. It first caps the usable lane count and link rate from three receiver capability bytes. It then works out the bandwidth the stream needs and picks the smallest rate/lane pair that carries it. Last, it produces the two clock-ratio pairs the transport needs: data M/N and link M/N. Both pairs are cut down to 24-bit fields.

The caller applies the inputs and pulses `start`. The block captures everything at that edge, so the inputs may change afterwards. When the result is ready, `done` goes high for one cycle, and the selection, flags and ratios all update in that same cycle. A request that no pair can carry raises `fail`. In that case the previous selection and ratios are kept.

Top module: `dp_link_planner`

## Requirements
- R1: The lane cap depends on the revision byte. When it is 8'h11 or above, the cap is bits [4:0] of the lane capability byte if that value is 1, 2 or 4; any other value gives 4. When the revision byte is below 8'h11, the cap is 4 whatever the lane byte holds.
- R2: The rate capability code 8'h0A allows both rates: 2.7 Gb/s (link clock 270000 kHz) and 1.62 Gb/s (162000 kHz). Every other code limits the search to 1.62 Gb/s. `rateCode` reports 8'h0A or 8'h06 respectively.
- R3: The required bandwidth is pixel clock × 3 for an external port. For an embedded panel it is (pixel clock × bits per pixel) >> 3, truncating.
- R4: The search tries lane counts 1, 2, 4 in that order, up to the cap. For each lane count it tries 1.62 and then 2.7, up to the cap. It takes the first pair whose link clock × lanes is at least the required bandwidth. `laneCnt` is one-hot encoded as 1, 2 or 4.
- R5: `tooHigh` is set when the required bandwidth exceeds the largest allowed link clock × the lane cap. `tooLow` is set when the pixel clock is below 10000 kHz. `modeOk` is set only when neither flag is set. All three flags update with every `done`.
- R6: Before reduction the ratio values are:
  - data M = pixel clock × 3
  - data N = chosen link clock × lanes
  - link M = pixel clock
  - link N = chosen link clock
- R7: Each M/N pair is reduced on its own. While either value of a pair exceeds 24'hFFFFFF, both values of that pair are shifted right by one bit.
- R8: `tuMinus1` is constantly 63, which encodes a transfer-unit size of 64.
- R9: When no pair fits, `fail` rises with `done`. `rateCode`, `laneCnt` and all ratio outputs keep their previous values. A later successful request clears `fail`.
- R10: Each accepted `start` produces exactly one `done`, one cycle wide. A `start` that arrives while a request is in progress is ignored.
- R11: After reset the outputs are:
  - `done`, `fail`, `modeOk`, `tooHigh`, `tooLow` are 0
  - `rateCode` is 8'h06 and `laneCnt` is 1
  - all ratios are 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| pixClkKhz | input | 24 | Pixel clock in kHz |
| bitsPerPixel | input | 8 | Bits per pixel, used for embedded panels |
| embPanel | input | 1 | 1 selects the embedded-panel bandwidth rule |
| capRev | input | 8 | Receiver revision byte |
| capMaxRate | input | 8 | Receiver maximum rate code |
| capMaxLanes | input | 8 | Receiver lane capability byte |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last request found no fitting pair |
| rateCode | output | 8 | Selected rate code (8'h06 or 8'h0A) |
| laneCnt | output | 3 | Selected lane count (1, 2 or 4) |
| modeOk | output | 1 | Mode is neither too fast nor too slow |
| tooHigh | output | 1 | Required bandwidth above capability |
| tooLow | output | 1 | Pixel clock below 10000 kHz |
| tuMinus1 | output | 6 | Transfer-unit size minus one |
| dataM | output | 24 | Reduced data M |
| dataN | output | 24 | Reduced data N |
| linkM | output | 24 | Reduced link M |
| linkN | output | 24 | Reduced link N |

## Verification
Two events can meet in one cycle: a new `start` arriving while the search or the reduction is still running. The bench provokes this by issuing a second request, with a different pixel clock, two cycles after the first. It judges the outcome by counting the `done` pulses, which must total one, and by checking that the published lane count and rate belong to the first request. The rejection path also brings two things together in the completion cycle: the flags must update while the selection holds still. The bench checks this by comparing the outputs against the preceding successful request.

// File: rtl/dp_link_planner_pkg.sv
package dp_link_planner_pkg;

  localparam int unsigned LCLK_W = 19;
  localparam logic [LCLK_W-1:0] RATE_LO_KHZ = 19'd162000;
  localparam logic [LCLK_W-1:0] RATE_HI_KHZ = 19'd270000;
  localparam logic [7:0] RATE_LO_CODE = 8'h06;
  localparam logic [7:0] RATE_HI_CODE = 8'h0A;
  localparam logic [7:0] REV_LANE_CAP = 8'h11;
  localparam int unsigned LOW_PIX_KHZ = 10000;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_REDUCE} plannerState_t;

  typedef struct packed {
    logic load;     // capture request and caps
    logic step;     // advance to next grid point
    logic commit;   // current grid point fits: load raw ratios
    logic shift;    // one reduction step
    logic publish;  // copy result to outputs
    logic reject;   // no pair fits: flags only
  } ctrlStrobe_t;

endpackage

// File: rtl/dp_link_planner_ctrl.sv
module dp_link_planner_ctrl
  import dp_link_planner_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        fits,
  input  logic        lastCand,
  input  logic        needShift,
  output ctrlStrobe_t strb,
  output logic        done,
  output logic        fail
);

  plannerState_t state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (fits) begin
          strb.commit = 1'b1;
          stateNext   = ST_REDUCE;
        end else if (lastCand) begin
          strb.reject = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          strb.step = 1'b1;
        end
      end
      ST_REDUCE: begin
        if (needShift) begin
          strb.shift = 1'b1;
        end else begin
          strb.publish = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.publish | strb.reject;
      if (strb.reject)       fail <= 1'b1;
      else if (strb.publish) fail <= 1'b0;
    end
  end

endmodule

// File: rtl/dp_link_planner_pair.sv
module dp_link_planner_pair #(
  parameter int unsigned WRK_W   = 26,
  parameter int unsigned RATIO_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [WRK_W-1:0]   loadM,
  input  logic [WRK_W-1:0]   loadN,
  input  logic               shift,
  output logic               needShift,
  output logic [RATIO_W-1:0] ratioM,
  output logic [RATIO_W-1:0] ratioN
);

  localparam logic [WRK_W-1:0] LIMIT = (WRK_W'(1) << RATIO_W) - WRK_W'(1);

  logic [WRK_W-1:0] workM, workN;

  assign needShift = (workM > LIMIT) || (workN > LIMIT);
  assign ratioM    = workM[RATIO_W-1:0];
  assign ratioN    = workN[RATIO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workM <= '0;
      workN <= '0;
    end else if (load) begin
      workM <= loadM;
      workN <= loadN;
    end else if (shift && needShift) begin
      workM <= workM >> 1;
      workN <= workN >> 1;
    end
  end

endmodule

// File: rtl/dp_link_planner_dp.sv
module dp_link_planner_dp
  import dp_link_planner_pkg::*;
#(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned BPP_W   = 8,
  parameter int unsigned RATIO_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [PIX_W-1:0]   pixClkKhz,
  input  logic [BPP_W-1:0]   bitsPerPixel,
  input  logic               embPanel,
  input  logic [7:0]         capRev,
  input  logic [7:0]         capMaxRate,
  input  logic [7:0]         capMaxLanes,
  output logic               fits,
  output logic               lastCand,
  output logic               needShift,
  output logic [7:0]         rateCode,
  output logic [2:0]         laneCnt,
  output logic               modeOk,
  output logic               tooHigh,
  output logic               tooLow,
  output logic [RATIO_W-1:0] dataM,
  output logic [RATIO_W-1:0] dataN,
  output logic [RATIO_W-1:0] linkM,
  output logic [RATIO_W-1:0] linkN
);

  localparam int unsigned BW_W    = PIX_W + BPP_W;
  localparam int unsigned AVAIL_W = LCLK_W + 2;
  localparam int unsigned DM_W    = PIX_W + 2;
  localparam int unsigned WRK_W   = maxOf(maxOf(DM_W, RATIO_W), AVAIL_W);
  localparam int unsigned CMP_W   = maxOf(BW_W, AVAIL_W);

  // request decode (valid on the load cycle)
  logic [BW_W-1:0]    prodEmb, reqNow;
  logic [1:0]         maxLaneNow;
  logic               maxRateNow;
  logic [AVAIL_W-1:0] maxAvailNow;
  logic               highNow, lowNow;

  assign prodEmb = BW_W'(pixClkKhz) * BW_W'(bitsPerPixel);
  assign reqNow  = embPanel ? (prodEmb >> 3) : (BW_W'(pixClkKhz) * BW_W'(2'd3));

  always_comb begin
    maxLaneNow = 2'd2;
    if (capRev >= REV_LANE_CAP) begin
      unique case (capMaxLanes[4:0])
        5'd1:    maxLaneNow = 2'd0;
        5'd2:    maxLaneNow = 2'd1;
        default: maxLaneNow = 2'd2;
      endcase
    end
  end

  assign maxRateNow  = (capMaxRate == RATE_HI_CODE);
  assign maxAvailNow = AVAIL_W'(maxRateNow ? RATE_HI_KHZ : RATE_LO_KHZ) << maxLaneNow;
  assign highNow     = CMP_W'(reqNow) > CMP_W'(maxAvailNow);
  assign lowNow      = pixClkKhz < PIX_W'(LOW_PIX_KHZ);

  // captured request and grid walker
  logic [PIX_W-1:0]   rPix;
  logic [BW_W-1:0]    rReq;
  logic [1:0]         rMaxLane, candLane;
  logic               rMaxRate, candRate;
  logic               pendHigh, pendLow;
  logic [LCLK_W-1:0]  candClk;
  logic [AVAIL_W-1:0] candAvail;

  assign candClk   = candRate ? RATE_HI_KHZ : RATE_LO_KHZ;
  assign candAvail = AVAIL_W'(candClk) << candLane;
  assign fits      = CMP_W'(candAvail) >= CMP_W'(rReq);
  assign lastCand  = (candLane == rMaxLane) && (candRate == rMaxRate);

  logic [7:0] selRate;
  logic [2:0] selLane;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rPix     <= '0;
      rReq     <= '0;
      rMaxLane <= '0;
      rMaxRate <= 1'b0;
      candLane <= '0;
      candRate <= 1'b0;
      pendHigh <= 1'b0;
      pendLow  <= 1'b0;
      selRate  <= RATE_LO_CODE;
      selLane  <= 3'd1;
    end else if (strb.load) begin
      rPix     <= pixClkKhz;
      rReq     <= reqNow;
      rMaxLane <= maxLaneNow;
      rMaxRate <= maxRateNow;
      candLane <= '0;
      candRate <= 1'b0;
      pendHigh <= highNow;
      pendLow  <= lowNow;
    end else if (strb.step) begin
      if (candRate == rMaxRate) begin
        candRate <= 1'b0;
        candLane <= candLane + 2'd1;
      end else begin
        candRate <= 1'b1;
      end
    end else if (strb.commit) begin
      selRate <= candRate ? RATE_HI_CODE : RATE_LO_CODE;
      selLane <= 3'd1 << candLane;
    end
  end

  // the two ratio pairs share one structure
  logic [1:0]               pairNeed;
  logic [1:0][WRK_W-1:0]    pairLoadM, pairLoadN;
  logic [1:0][RATIO_W-1:0]  pairM, pairN;

  assign pairLoadM[0] = WRK_W'(rPix) * WRK_W'(2'd3);
  assign pairLoadN[0] = WRK_W'(candAvail);
  assign pairLoadM[1] = WRK_W'(rPix);
  assign pairLoadN[1] = WRK_W'(candClk);

  for (genvar g = 0; g < 2; g++) begin : gPair
    dp_link_planner_pair #(.WRK_W(WRK_W), .RATIO_W(RATIO_W)) uPair (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strb.commit),
      .loadM    (pairLoadM[g]),
      .loadN    (pairLoadN[g]),
      .shift    (strb.shift),
      .needShift(pairNeed[g]),
      .ratioM   (pairM[g]),
      .ratioN   (pairN[g])
    );
  end

  assign needShift = |pairNeed;

  // published results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateCode <= RATE_LO_CODE;
      laneCnt  <= 3'd1;
      modeOk   <= 1'b0;
      tooHigh  <= 1'b0;
      tooLow   <= 1'b0;
      dataM    <= '0;
      dataN    <= '0;
      linkM    <= '0;
      linkN    <= '0;
    end else begin
      if (strb.publish || strb.reject) begin
        tooHigh <= pendHigh;
        tooLow  <= pendLow;
        modeOk  <= !pendHigh && !pendLow;
      end
      if (strb.publish) begin
        rateCode <= selRate;
        laneCnt  <= selLane;
        dataM    <= pairM[0];
        dataN    <= pairN[0];
        linkM    <= pairM[1];
        linkN    <= pairN[1];
      end
    end
  end

endmodule

// File: rtl/dp_link_planner.sv
module dp_link_planner
  import dp_link_planner_pkg::*;
#(
  parameter int unsigned PIX_W   = 24,
  parameter int unsigned BPP_W   = 8,
  parameter int unsigned RATIO_W = 24,
  parameter int unsigned TU_SIZE = 64,
  localparam int unsigned TU_W   = $clog2(TU_SIZE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PIX_W-1:0]   pixClkKhz,
  input  logic [BPP_W-1:0]   bitsPerPixel,
  input  logic               embPanel,
  input  logic [7:0]         capRev,
  input  logic [7:0]         capMaxRate,
  input  logic [7:0]         capMaxLanes,
  output logic               done,
  output logic               fail,
  output logic [7:0]         rateCode,
  output logic [2:0]         laneCnt,
  output logic               modeOk,
  output logic               tooHigh,
  output logic               tooLow,
  output logic [TU_W-1:0]    tuMinus1,
  output logic [RATIO_W-1:0] dataM,
  output logic [RATIO_W-1:0] dataN,
  output logic [RATIO_W-1:0] linkM,
  output logic [RATIO_W-1:0] linkN
);

  ctrlStrobe_t strb;
  logic        fits, lastCand, needShift;

  assign tuMinus1 = TU_W'(TU_SIZE - 1);

  dp_link_planner_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .fits     (fits),
    .lastCand (lastCand),
    .needShift(needShift),
    .strb     (strb),
    .done     (done),
    .fail     (fail)
  );

  dp_link_planner_dp #(.PIX_W(PIX_W), .BPP_W(BPP_W), .RATIO_W(RATIO_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pixClkKhz   (pixClkKhz),
    .bitsPerPixel(bitsPerPixel),
    .embPanel    (embPanel),
    .capRev      (capRev),
    .capMaxRate  (capMaxRate),
    .capMaxLanes (capMaxLanes),
    .fits        (fits),
    .lastCand    (lastCand),
    .needShift   (needShift),
    .rateCode    (rateCode),
    .laneCnt     (laneCnt),
    .modeOk      (modeOk),
    .tooHigh     (tooHigh),
    .tooLow      (tooLow),
    .dataM       (dataM),
    .dataN       (dataN),
    .linkM       (linkM),
    .linkN       (linkN)
  );

endmodule

// File: rtl/dp_link_planner_chk.sv
module dp_link_planner_chk (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic       fail,
  input logic [7:0] rateCode,
  input logic [2:0] laneCnt,
  input logic       modeOk,
  input logic       tooHigh
);

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a rejected request leaves the selection where it was
  assert_fail_keeps_sel_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> ($stable(rateCode) && $stable(laneCnt)));

  // R5: a rejection is always reported as too high and not valid
  assert_fail_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> (tooHigh && !modeOk));

  // R4: lane count is a single one-hot value
  assert_lane_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(laneCnt) == 1);

  // R2: only the two rate codes ever appear
  assert_rate_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 8'h06) || (rateCode == 8'h0A));

endmodule

bind dp_link_planner dp_link_planner_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .fail    (fail),
  .rateCode(rateCode),
  .laneCnt (laneCnt),
  .modeOk  (modeOk),
  .tooHigh (tooHigh)
);

// File: tb/dp_link_planner_bench.sv
module dp_link_planner_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] pixClkKhz = '0;
  logic [7:0]  bitsPerPixel = '0;
  logic        embPanel = 1'b0;
  logic [7:0]  capRev = '0;
  logic [7:0]  capMaxRate = '0;
  logic [7:0]  capMaxLanes = '0;
  logic        done, fail, modeOk, tooHigh, tooLow;
  logic [7:0]  rateCode;
  logic [2:0]  laneCnt;
  logic [5:0]  tuMinus1;
  logic [23:0] dataM, dataN, linkM, linkN;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dp_link_planner u_dp_link_planner (
    .clk(clk), .rstN(rstN), .start(start), .pixClkKhz(pixClkKhz),
    .bitsPerPixel(bitsPerPixel), .embPanel(embPanel), .capRev(capRev),
    .capMaxRate(capMaxRate), .capMaxLanes(capMaxLanes), .done(done),
    .fail(fail), .rateCode(rateCode), .laneCnt(laneCnt), .modeOk(modeOk),
    .tooHigh(tooHigh), .tooLow(tooLow), .tuMinus1(tuMinus1),
    .dataM(dataM), .dataN(dataN), .linkM(linkM), .linkN(linkN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic setReq(input logic [7:0] rev, input logic [7:0] rate, input logic [7:0] lanes,
                        input logic emb, input logic [7:0] bpp, input logic [23:0] pix);
    capRev = rev; capMaxRate = rate; capMaxLanes = lanes;
    embPanel = emb; bitsPerPixel = bpp; pixClkKhz = pix;
  endtask

  // one request: pulse start, wait for done, confirm the pulse ends
  task automatic runReq(input logic [7:0] rev, input logic [7:0] rate, input logic [7:0] lanes,
                        input logic emb, input logic [7:0] bpp, input logic [23:0] pix);
    bit seen = 0;
    @(negedge clk);
    setReq(rev, rate, lanes, emb, bpp, pix);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check("R10 done seen", 32'(seen), 32'd1);
    @(negedge clk);
    check("R10 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic checkSel(input string tag, input logic [7:0] rc, input logic [2:0] ln);
    check({tag, " rateCode"}, 32'(rateCode), 32'(rc));
    check({tag, " laneCnt"}, 32'(laneCnt), 32'(ln));
  endtask

  task automatic checkRatios(input string tag, input int dm, input int dn, input int lm, input int ln);
    check({tag, " dataM"}, 32'(dataM), 32'(dm));
    check({tag, " dataN"}, 32'(dataN), 32'(dn));
    check({tag, " linkM"}, 32'(linkM), 32'(lm));
    check({tag, " linkN"}, 32'(linkN), 32'(ln));
  endtask

  task automatic checkFlags(input string tag, input logic ok, input logic hi, input logic lo, input logic fl);
    check({tag, " modeOk"}, 32'(modeOk), 32'(ok));
    check({tag, " tooHigh"}, 32'(tooHigh), 32'(hi));
    check({tag, " tooLow"}, 32'(tooLow), 32'(lo));
    check({tag, " fail"}, 32'(fail), 32'(fl));
  endtask

  task automatic tReset();
    check("R11 done", 32'(done), 32'd0);
    checkSel("R11", 8'h06, 3'd1);
    checkFlags("R11", 1'b0, 1'b0, 1'b0, 1'b0);
    checkRatios("R11", 0, 0, 0, 0);
    check("R8 tuMinus1", 32'(tuMinus1), 32'd63);
  endtask

  task automatic tExternalBasic();
    // required 445500: two lanes at 2.7 is the first fit; bits above [4:0] of lane byte ignored
    runReq(8'h11, 8'h0A, 8'h84, 1'b0, 8'd24, 24'd148500);
    checkSel("R4 ext basic", 8'h0A, 3'd2);
    checkRatios("R6 ext basic", 445500, 540000, 148500, 270000);
    checkFlags("R5 ext basic", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tOldRevision();
    // below 0x11 the lane byte (1) is ignored: cap stays 4
    runReq(8'h10, 8'h06, 8'h01, 1'b0, 8'd24, 24'd200000);
    checkSel("R1 old revision", 8'h06, 3'd4);
    check("R6 old revision dataN", 32'(dataN), 32'd648000);
  endtask

  task automatic tBadLaneOrder();
    // lane byte 3 is not legal -> cap 4; 4 lanes at 1.62 fits before 4 lanes at 2.7
    runReq(8'h12, 8'h0A, 8'h03, 1'b0, 8'd24, 24'd200000);
    checkSel("R1 R4 bad lane byte", 8'h06, 3'd4);
  endtask

  task automatic tOneLaneAndFail();
    runReq(8'h11, 8'h0A, 8'h01, 1'b0, 8'd24, 24'd80000);
    checkSel("R1 one lane cap", 8'h0A, 3'd1);
    checkRatios("R6 one lane", 240000, 270000, 80000, 270000);
    // 300000 > 270000: no pair fits, previous result must stay
    runReq(8'h11, 8'h0A, 8'h01, 1'b0, 8'd24, 24'd100000);
    checkSel("R9 fail keeps", 8'h0A, 3'd1);
    checkRatios("R9 fail keeps", 240000, 270000, 80000, 270000);
    checkFlags("R9 fail flags", 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic tBadRateCode();
    // code 0x14 is treated as 1.62 only; two lanes needed for 180000
    runReq(8'h11, 8'h14, 8'h02, 1'b0, 8'd24, 24'd60000);
    checkSel("R2 bad rate code", 8'h06, 3'd2);
    check("R9 fail cleared", 32'(fail), 32'd0);
  endtask

  task automatic tEmbedded();
    // (100000*18)>>3 = 225000 -> one lane at 2.7; data M still uses 3 bytes
    runReq(8'h11, 8'h0A, 8'h04, 1'b1, 8'd18, 24'd100000);
    checkSel("R3 embedded", 8'h0A, 3'd1);
    checkRatios("R3 embedded", 300000, 270000, 100000, 270000);
  endtask

  task automatic tReduce();
    // required 1000000 -> 4 lanes at 2.7; data M 24000000 needs one shift, link pair none
    runReq(8'h11, 8'h0A, 8'h04, 1'b1, 8'd1, 24'd8000000);
    checkSel("R7 reduce", 8'h0A, 3'd4);
    checkRatios("R7 reduce", 12000000, 540000, 8000000, 270000);
  endtask

  task automatic tLowBoundary();
    runReq(8'h11, 8'h0A, 8'h04, 1'b0, 8'd24, 24'd9999);
    checkFlags("R5 below low", 1'b0, 1'b0, 1'b1, 1'b0);
    checkSel("R5 below low still selects", 8'h06, 3'd1);
    runReq(8'h11, 8'h0A, 8'h04, 1'b0, 8'd24, 24'd10000);
    checkFlags("R5 at low", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tHighBoundary();
    runReq(8'h11, 8'h0A, 8'h04, 1'b0, 8'd24, 24'd360000);
    checkFlags("R5 at max", 1'b1, 1'b0, 1'b0, 1'b0);
    checkSel("R4 at max", 8'h0A, 3'd4);
    runReq(8'h11, 8'h0A, 8'h04, 1'b0, 8'd24, 24'd360001);
    checkFlags("R5 above max", 1'b0, 1'b1, 1'b0, 1'b1);
    checkSel("R9 above max keeps", 8'h0A, 3'd4);
  endtask

  task automatic tBusyStart();
    int doneCnt = 0;
    // first run establishes a distinct prior selection
    runReq(8'h11, 8'h06, 8'h01, 1'b0, 8'd24, 24'd20000);
    checkSel("R10 prior", 8'h06, 3'd1);
    @(negedge clk);
    setReq(8'h11, 8'h0A, 8'h04, 1'b0, 8'd24, 24'd360000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (done) doneCnt++;
    setReq(8'h11, 8'h0A, 8'h04, 1'b0, 8'd24, 24'd20000);
    start = 1'b1;
    @(negedge clk);
    if (done) doneCnt++;
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) doneCnt++;
    end
    check("R10 one done for busy start", 32'(doneCnt), 32'd1);
    checkSel("R10 first request wins", 8'h0A, 3'd4);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExternalBasic();
    tOldRevision();
    tBadLaneOrder();
    tOneLaneAndFail();
    tBadRateCode();
    tEmbedded();
    tReduce();
    tLowBoundary();
    tHighBoundary();
    tBusyStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule